// File: doc/BRIEF.md
# Mode-Selectable Compare and Vote Unit

This unit sits at the output of a cluster of four execution cells. Each cell delivers a data word and a parity bit. A small control word picks how the cluster's results are formed. In triple mode, three cells are majority-voted and a single bad cell is masked. In dual mode, two cells are compared, and their parity bits decide which copy can be trusted. In the two single modes, all four cells are forwarded untouched. The results leave a register stage together with two flags. One flag reports an error that was found but could not be masked. The other reports a fault that was repaired.

The 6-bit control word is kept as three copies. A bitwise majority of the three gives the effective control word. That voted value is written back into every copy on each clock, so an upset in one copy is repaired before an upset in a second copy can combine with it. The control word also supplies the context index handed to the cells. That index is only used in the multi-context single mode. The multi-context mode is the one without protected configuration, so it can hold several contexts. A fault-injection port lets one copy be disturbed on purpose.

Top module: `mode_vote_unit`

## Requirements
- R1: `ctrl_we` loads `ctrl_wdata` into all three copies at the clock edge. The fields are: bits [1:0] mode, with 00 = triple vote, 01 = dual compare, 10 = single with one context, 11 = single with several contexts; bits [3:2] cell group; bits [5:4] context index. Data presented after that edge is handled under the new word.
- R2: When not writing, every copy is rewritten with the bitwise majority at each edge. A fault injected with `upset_en` XORs `upset_mask` into copy `upset_sel` (0..2; 3 selects none). The outputs never change because of an injection, including when the three copies are upset one after another on successive cycles.
- R3: In triple mode, lane 0 of `res_data` is the bitwise majority of three cells, and lanes 1..3 are zero. The group field selects the three cells: 0 gives cells 0,1,2; 1 gives cells 1,2,3; 2 gives cells 0,2,3; 3 gives cells 0,1,3. Parity bits are ignored in this mode.
- R4: In triple mode, `cor_o` is set when exactly one of the three cells differs from the voted word, and `err_o` is set when two or more differ. Neither flag is set when all three cells agree.
- R5: In dual mode, the group field selects the pair (first, second): 0 gives (0,1); 1 gives (2,3); 2 gives (0,2); 3 gives (1,3). Parity is even, meaning the XOR of the data bits and the parity bit is 0. When the two cells match in data and parity and both pass parity, the data goes to lane 0, lanes 1..3 are zero, and no flag is set.
- R6: In dual mode, if exactly one of the pair fails parity, the other cell's data is forwarded and `cor_o` is set.
- R7: In dual mode, every other case sets `err_o` and forwards the first cell of the pair. These cases are: both cells pass parity but differ, or both cells fail parity.
- R8: In the two single modes, lane i of `res_data` equals cell i for all four lanes, both flags are zero, and parity is ignored.
- R9: `ctx_sel` equals the context field in mode 11 and is zero in every other mode.
- R10: All outputs are registered with one cycle of latency. Synchronous reset clears the outputs and the control word, which leaves triple mode, group 0 and context 0. `err_o` and `cor_o` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 6 | New control word |
| upset_en | input | 1 | Inject a fault into one control copy |
| upset_sel | input | 2 | Copy to disturb (3 = none) |
| upset_mask | input | 6 | Bits to flip in that copy |
| cell_data | input | 4*W | Cell words, cell i at bits [i*W +: W] |
| cell_par | input | 4 | Even parity bit of each cell |
| res_data | output | 4*W | Result lanes |
| err_o | output | 1 | Fault detected but not masked |
| cor_o | output | 1 | Fault detected and masked |
| ctx_sel | output | 2 | Context index driven to the cells |

## Verification
A wrong voted control word shows up at the ports one cycle later. It appears as a wrong `ctx_sel`, or as lanes being zeroed or passed in the wrong pattern. The fault-injection sequence therefore checks the outputs after every injection cycle, and a missing scrub becomes visible by the third cycle. A wrong group choice or wrong arbitration in the voter or comparator gives a wrong lane 0 word or wrong flags in the cycle after the data is presented. Random data with one, two or parity-only corruptions reaches those paths under every mode and group.

// File: rtl/cvu_pkg.sv
package cvu_pkg;

    localparam int NCELL  = 4;
    localparam int NCOPY  = 3;
    localparam int CTRL_W = 6;
    localparam int IDX_W  = $clog2(NCELL);

    typedef enum logic [1:0] {
        MODE_TMR = 2'b00,
        MODE_DMR = 2'b01,
        MODE_SMS = 2'b10,
        MODE_SMM = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] ctx;
        logic [1:0] group;
        mode_e      mode;
    } ctrl_t;

    typedef struct packed {
        logic [IDX_W-1:0] c;
        logic [IDX_W-1:0] b;
        logic [IDX_W-1:0] a;
    } trio_t;

    typedef struct packed {
        logic [IDX_W-1:0] second;
        logic [IDX_W-1:0] first;
    } pair_t;

    typedef struct packed {
        logic err;
        logic cor;
    } flag_t;

    function automatic trio_t trio_pick(input logic [1:0] grp);
        trio_t t;
        case (grp)
            2'd0:    t = '{c: 2'd2, b: 2'd1, a: 2'd0};
            2'd1:    t = '{c: 2'd3, b: 2'd2, a: 2'd1};
            2'd2:    t = '{c: 2'd3, b: 2'd2, a: 2'd0};
            default: t = '{c: 2'd3, b: 2'd1, a: 2'd0};
        endcase
        return t;
    endfunction

    function automatic pair_t pair_pick(input logic [1:0] grp);
        pair_t p;
        case (grp)
            2'd0:    p = '{second: 2'd1, first: 2'd0};
            2'd1:    p = '{second: 2'd3, first: 2'd2};
            2'd2:    p = '{second: 2'd2, first: 2'd0};
            default: p = '{second: 2'd3, first: 2'd1};
        endcase
        return p;
    endfunction

    function automatic logic [CTRL_W-1:0] maj3(input logic [CTRL_W-1:0] x,
                                               input logic [CTRL_W-1:0] y,
                                               input logic [CTRL_W-1:0] z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/cvu_ctrl_store.sv
module cvu_ctrl_store
    import cvu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              upset_en,
    input  logic [1:0]        upset_sel,
    input  logic [CTRL_W-1:0] upset_mask,
    output ctrl_t             voted
);

    logic [CTRL_W-1:0] copy_q [NCOPY];
    logic [CTRL_W-1:0] vote_w;

    assign vote_w = maj3(copy_q[0], copy_q[1], copy_q[2]);
    assign voted  = ctrl_t'(vote_w);

    // each copy is refreshed from the vote every cycle (scrubbing)
    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) begin
                copy_q[i] <= '0;
            end else if (we) begin
                copy_q[i] <= wdata;
            end else if (upset_en && (upset_sel == 2'(i))) begin
                copy_q[i] <= vote_w ^ upset_mask;
            end else begin
                copy_q[i] <= vote_w;
            end
        end
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> (voted == ctrl_t'($past(wdata))));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(voted));

endmodule

// File: rtl/cvu_tmr_voter.sv
module cvu_tmr_voter #(
    parameter int W = 8
) (
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    input  logic [W-1:0]   in_c,
    output logic [W-1:0]   voted,
    output cvu_pkg::flag_t flags
);

    logic [1:0] n_bad;

    always_comb begin
        voted = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        n_bad = {1'b0, in_a != voted} + {1'b0, in_b != voted} + {1'b0, in_c != voted};
        flags.cor = (n_bad == 2'd1);
        flags.err = (n_bad >= 2'd2);
    end

endmodule

// File: rtl/cvu_dmr_cmp.sv
module cvu_dmr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0]   in_a,
    input  logic           par_a,
    input  logic [W-1:0]   in_b,
    input  logic           par_b,
    output logic [W-1:0]   chosen,
    output cvu_pkg::flag_t flags
);

    logic ok_a, ok_b, same;

    always_comb begin
        ok_a   = ~(^{in_a, par_a});
        ok_b   = ~(^{in_b, par_b});
        same   = (in_a == in_b) && (par_a == par_b);
        chosen = in_a;
        flags  = '0;
        if (same && ok_a) begin
            chosen = in_a;
        end else if (ok_a && !ok_b) begin
            chosen    = in_a;
            flags.cor = 1'b1;
        end else if (!ok_a && ok_b) begin
            chosen    = in_b;
            flags.cor = 1'b1;
        end else begin
            chosen    = in_a;
            flags.err = 1'b1;
        end
    end

endmodule

// File: rtl/mode_vote_unit.sv
module mode_vote_unit
    import cvu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic                 upset_en,
    input  logic [1:0]           upset_sel,
    input  logic [CTRL_W-1:0]    upset_mask,
    input  logic [NCELL*W-1:0]   cell_data,
    input  logic [NCELL-1:0]     cell_par,
    output logic [NCELL*W-1:0]   res_data,
    output logic                 err_o,
    output logic                 cor_o,
    output logic [1:0]           ctx_sel
);

    localparam int OUT_W = NCELL * W;

    ctrl_t          cw;
    logic [W-1:0]   lane [NCELL];
    trio_t          trio;
    pair_t          pair;
    logic [W-1:0]   t_a, t_b, t_c, t_y;
    logic [W-1:0]   d_a, d_b, d_y;
    logic           p_a, p_b;
    flag_t          t_f, d_f, nxt_f;
    logic [OUT_W-1:0] nxt_data;
    logic [1:0]     nxt_ctx;

    cvu_ctrl_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (ctrl_we),
        .wdata      (ctrl_wdata),
        .upset_en   (upset_en),
        .upset_sel  (upset_sel),
        .upset_mask (upset_mask),
        .voted      (cw)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_lane
        assign lane[i] = cell_data[i*W +: W];
    end

    assign trio = trio_pick(cw.group);
    assign pair = pair_pick(cw.group);
    assign t_a  = lane[trio.a];
    assign t_b  = lane[trio.b];
    assign t_c  = lane[trio.c];
    assign d_a  = lane[pair.first];
    assign d_b  = lane[pair.second];
    assign p_a  = cell_par[pair.first];
    assign p_b  = cell_par[pair.second];

    cvu_tmr_voter #(.W(W)) u_vote (
        .in_a  (t_a),
        .in_b  (t_b),
        .in_c  (t_c),
        .voted (t_y),
        .flags (t_f)
    );

    cvu_dmr_cmp #(.W(W)) u_cmp (
        .in_a   (d_a),
        .par_a  (p_a),
        .in_b   (d_b),
        .par_b  (p_b),
        .chosen (d_y),
        .flags  (d_f)
    );

    always_comb begin
        nxt_data = '0;
        nxt_f    = '0;
        unique case (cw.mode)
            MODE_TMR: begin
                nxt_data[W-1:0] = t_y;
                nxt_f           = t_f;
            end
            MODE_DMR: begin
                nxt_data[W-1:0] = d_y;
                nxt_f           = d_f;
            end
            default: begin
                nxt_data = cell_data;
            end
        endcase
        nxt_ctx = (cw.mode == MODE_SMM) ? cw.ctx : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data <= '0;
            err_o    <= 1'b0;
            cor_o    <= 1'b0;
            ctx_sel  <= 2'd0;
        end else begin
            res_data <= nxt_data;
            err_o    <= nxt_f.err;
            cor_o    <= nxt_f.cor;
            ctx_sel  <= nxt_ctx;
        end
    end

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_o, cor_o}));

    assert_tmr_agree_R3: assert property (@(posedge clk) disable iff (rst)
        (cw.mode == MODE_TMR && t_a == t_b && t_b == t_c)
        |=> (res_data[W-1:0] == $past(t_a) && !err_o && !cor_o));

    assert_dmr_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (cw.mode == MODE_DMR && d_a == d_b && p_a == p_b && !(^{d_a, p_a}))
        |=> (res_data[W-1:0] == $past(d_a) && !err_o && !cor_o));

    assert_pass_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cw.mode == MODE_SMS || cw.mode == MODE_SMM)
        |=> (!err_o && !cor_o && res_data == $past(cell_data)));

    assert_ctx_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (cw.mode != MODE_SMM) |=> (ctx_sel == 2'd0));

endmodule

// File: tb/tb_mode_vote_unit.sv
module tb_mode_vote_unit;

    localparam int W  = 8;
    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            ctrl_we;
    logic [5:0]      ctrl_wdata;
    logic            upset_en;
    logic [1:0]      upset_sel;
    logic [5:0]      upset_mask;
    logic [NC*W-1:0] cell_data;
    logic [NC-1:0]   cell_par;
    logic [NC*W-1:0] res_data;
    logic            err_o, cor_o;
    logic [1:0]      ctx_sel;

    int  n_checks = 0;
    int  n_fail   = 0;
    logic [5:0] cur_cw;

    always #2.5 clk = ~clk;

    mode_vote_unit #(.W(W)) dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .upset_en(upset_en), .upset_sel(upset_sel), .upset_mask(upset_mask),
        .cell_data(cell_data), .cell_par(cell_par), .res_data(res_data),
        .err_o(err_o), .cor_o(cor_o), .ctx_sel(ctx_sel)
    );

    function automatic logic [W-1:0] get_lane(input logic [NC*W-1:0] d, input int i);
        return d[i*W +: W];
    endfunction

    function automatic logic evenp(input logic [W-1:0] v);
        return ^v;
    endfunction

    // reference behaviour derived from the requirement list
    function automatic void model(input logic [5:0] cw, input logic [NC*W-1:0] d,
                                  input logic [NC-1:0] p, output logic [NC*W-1:0] y,
                                  output logic e, output logic c, output logic [1:0] cx);
        int md, grp, skip, k, bad, f, s;
        logic [W-1:0] v [3];
        logic [W-1:0] m;
        logic oka, okb;
        md  = int'(cw[1:0]);
        grp = int'(cw[3:2]);
        y = '0; e = 1'b0; c = 1'b0;
        cx = (md == 3) ? cw[5:4] : 2'd0;
        if (md == 0) begin
            skip = (grp + 3) % 4;
            k = 0;
            for (int i = 0; i < NC; i++) if (i != skip) begin v[k] = get_lane(d, i); k++; end
            for (int b = 0; b < W; b++) m[b] = (int'(v[0][b]) + int'(v[1][b]) + int'(v[2][b])) >= 2;
            bad = 0;
            for (int i = 0; i < 3; i++) if (v[i] != m) bad++;
            y[W-1:0] = m;
            c = (bad == 1);
            e = (bad > 1);
        end else if (md == 1) begin
            f = (grp == 0) ? 0 : (grp == 1) ? 2 : (grp == 2) ? 0 : 1;
            s = (grp == 0) ? 1 : (grp == 1) ? 3 : (grp == 2) ? 2 : 3;
            oka = (evenp(get_lane(d, f)) == p[f]);
            okb = (evenp(get_lane(d, s)) == p[s]);
            if (oka && okb && get_lane(d, f) == get_lane(d, s)) y[W-1:0] = get_lane(d, f);
            else if (oka && !okb) begin y[W-1:0] = get_lane(d, f); c = 1'b1; end
            else if (!oka && okb) begin y[W-1:0] = get_lane(d, s); c = 1'b1; end
            else begin y[W-1:0] = get_lane(d, f); e = 1'b1; end
        end else begin
            y = d;
        end
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [5:0] w);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
        cur_cw = w;
    endtask

    task automatic step_check(input logic [NC*W-1:0] d, input logic [NC-1:0] p,
                              input logic [5:0] cw, input string req);
        logic [NC*W-1:0] ey; logic ee, ec; logic [1:0] ex;
        cell_data = d; cell_par = p;
        model(cw, d, p, ey, ee, ec, ex);
        @(posedge clk); #1;
        check(res_data == ey, req, "data", 64'(res_data), 64'(ey));
        check({err_o, cor_o} == {ee, ec}, req, "flags {err,cor}", 64'({err_o, cor_o}), 64'({ee, ec}));
        check(ctx_sel == ex, req, "ctx_sel", 64'(ctx_sel), 64'(ex));
        @(negedge clk);
    endtask

    function automatic logic [NC-1:0] good_par(input logic [NC*W-1:0] d);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = ^get_lane(d, i);
        return r;
    endfunction

    function automatic logic [NC*W-1:0] rep(input logic [W-1:0] v);
        return {v, v, v, v};
    endfunction

    initial begin : watchdog
        #500000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [NC*W-1:0] d;
        logic [NC-1:0]   p;
        void'($urandom(32'd20240611));
        rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = '0; upset_en = 1'b0;
        upset_sel = 2'd3; upset_mask = '0; cell_data = '0; cell_par = '0;
        cur_cw = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check(res_data == '0 && !err_o && !cor_o && ctx_sel == 2'd0, "R10", "reset outputs",
              64'({res_data, err_o, cor_o, ctx_sel}), 64'(0));
        @(negedge clk); rst = 1'b0;

        // R10 control cleared: triple mode, group 0
        d = {8'h11, 8'h5A, 8'h5A, 8'h5A};
        step_check(d, good_par(d), 6'h00, "R10");

        // R3/R4 triple vote, group 1 (cells 1,2,3), cell 0 ignored
        write_ctrl(6'b00_01_00);
        d = {8'hC3, 8'hC3, 8'hC3, 8'h00};
        step_check(d, 4'h0, cur_cw, "R3");
        d = {8'hC7, 8'hC3, 8'hC3, 8'h00};
        step_check(d, 4'h0, cur_cw, "R4");
        d = {8'hC7, 8'hC1, 8'hC3, 8'hC3};
        step_check(d, 4'h0, cur_cw, "R4");

        // R5/R6/R7 dual mode, group 3 (cells 1,3)
        write_ctrl(6'b00_11_01);
        d = {8'h3C, 8'hFF, 8'h3C, 8'hFF};
        step_check(d, good_par(d), cur_cw, "R5");
        d = {8'h3D, 8'h00, 8'h3C, 8'h00};
        p = good_par(d); p[3] = ~p[3];
        step_check(d, p, cur_cw, "R6");
        p = good_par(d); p[1] = ~p[1];
        step_check(d, p, cur_cw, "R6");
        step_check(d, good_par(d), cur_cw, "R7");
        p = good_par(d); p[1] = ~p[1]; p[3] = ~p[3];
        step_check(d, p, cur_cw, "R7");

        // R8/R9 single modes, context only in multi-context mode
        write_ctrl(6'b11_00_10);
        d = {8'h01, 8'h23, 8'h45, 8'h67};
        step_check(d, 4'hA, cur_cw, "R9");
        write_ctrl(6'b10_01_11);
        step_check(d, 4'h5, cur_cw, "R8");

        // R2 upsets hit each copy on successive cycles; scrub keeps vote intact
        write_ctrl(6'b11_10_11);
        for (int k = 0; k < 3; k++) begin
            upset_en = 1'b1; upset_sel = 2'(k); upset_mask = 6'h3F;
            step_check(d, 4'h0, cur_cw, "R2");
        end
        upset_en = 1'b0; upset_sel = 2'd3;
        step_check(d, 4'h0, cur_cw, "R2");
        step_check(d, 4'h0, cur_cw, "R2");

        // R1 load then immediate use
        write_ctrl(6'b00_10_00);
        d = {8'h77, 8'h77, 8'h12, 8'h77};
        step_check(d, 4'h0, cur_cw, "R1");

        // random mix
        for (int it = 0; it < 600; it++) begin
            logic [W-1:0] base;
            int kind, l1, l2;
            string req;
            if (it % 25 == 0) write_ctrl(6'($urandom));
            base = W'($urandom);
            d = rep(base);
            p = good_par(d);
            kind = int'($urandom % 5);
            l1 = int'($urandom % 4);
            l2 = (l1 + 1 + int'($urandom % 3)) % 4;
            if (kind == 1) d[l1*W +: W] = d[l1*W +: W] ^ W'($urandom | 1);
            if (kind == 2) begin
                d[l1*W +: W] = d[l1*W +: W] ^ W'($urandom | 1);
                d[l2*W +: W] = d[l2*W +: W] ^ W'($urandom | 2);
            end
            if (kind == 3) p[l1] = ~p[l1];
            if (kind == 4) begin
                d[l1*W +: W] = d[l1*W +: W] ^ W'($urandom | 1);
                p = good_par(d);
            end
            case (cur_cw[1:0])
                2'b00:   req = "R3/R4";
                2'b01:   req = "R5/R6/R7";
                2'b11:   req = "R8/R9";
                default: req = "R8";
            endcase
            step_check(d, p, cur_cw, req);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

endmodule